// File: doc/BRIEF.md
# Pixel Array Readout Timing Generator

This block produces the framing for a progressive-scan readout of a pixel array. It runs entirely on the pixel clock. From a flat configuration bus it derives a readout window, the length of each row including horizontal blanking, and the number of rows per frame including vertical blanking. It drives a frame strobe, a line strobe, and the row and column addresses for the pixel source that sits downstream. The pixel word from that source comes back in and is either passed through or replaced by a fixed test pattern.

The geometry part of the configuration (window, blanking, skip, integration rows) is copied into a shadow register only when a new frame starts, so a write in the middle of a frame never tears that frame. A hold bit blocks even that copy. The mode part (line strobe format, snapshot, hold, test pattern) acts at once. In free-running mode frames follow each other with no gap. In snapshot mode the block waits, idle, for a trigger pulse or a restart pulse and then reads out one frame. A restart pulse abandons the frame in progress and begins again at the first row.

Top module: `rdt_readout_timer`

## Requirements
- R1: With skipping off, a frame reads `rows_m1+1` rows and `cols_m1+1` columns. Row addresses start at `row_first` and column addresses start at `col_first`, and both step by one.
- R2: A row lasts `npix + 244 + max(hblank,19) - 19` clocks, where `npix` is the number of pixels output per line. Any `hblank` below 19 gives the same row length as 19.
- R3: Each row begins with one clock of line strobe low. The strobe is then high for exactly `npix` consecutive clocks, with one new column address on each of those clocks.
- R4: With `row_skip` or `col_skip` set, only offsets from the window start whose bit 1 is zero are read (0,1,4,5,8,9,...), so about half as many rows or columns come out.
- R5: `lv_fmt` encoding: 2'b00 gives a line strobe only on pixel clocks of active rows; 2'b01 also pulses it at the same row positions during vertical blanking rows; 2'b10 and 2'b11 give that continuous strobe XOR the frame strobe.
- R6: The frame strobe rises in the clock before the first line strobe of a frame and falls in the clock after the last pixel of the last active row. A frame is the active rows followed by `vblank+1` blanking rows.
- R7: When `int_rows` exceeds active rows plus `vblank+1`, the frame is lengthened with blanking rows to exactly `int_rows` rows.
- R8: Geometry fields take effect only at the start of a frame. While `hold` is 1 at that point, the previous geometry is kept for the new frame.
- R9: With `snap_en` set, the strobes stay low after a frame until a `trigger` or `restart` pulse arrives. Exactly one frame, timed like a free-running frame, then follows.
- R10: A one-clock `restart` pulse during a frame makes the next clock the first clock of a new frame, at row 0 with the frame strobe high.
- R11: With `tpat_en` set, the pixel output on active pixels is `tpat_val` on even column addresses and `~tpat_val` on odd ones. With it clear, the output is `pix_in`. Frame timing is the same in both cases.
- R12: A synchronous active-high reset leaves the block idle with both strobes low. In free-running mode the first clock after reset is released already shows row 0 with the frame strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bus | input | CFG_W | Packed `rdt_cfg_t`: geometry fields, then mode fields |
| trigger | input | 1 | Starts one frame in snapshot mode |
| restart | input | 1 | One-clock request that abandons the current frame and starts a new one |
| pix_in | input | PIX_W | Pixel word from the array source at the current address |
| frame_valid | output | 1 | Frame strobe |
| line_valid | output | 1 | Line strobe in the selected format |
| row_addr | output | ADDR_W | Row address being read |
| col_addr | output | ADDR_W | Column address being read |
| pix_out | output | PIX_W | Pixel data or test pattern on active pixels |

## Verification
The bench runs frames with a plain window, with a long horizontal blanking value, with row and column skipping, with each of the line strobe formats, with a long integration count, and with the test pattern, plus frames cut short by a restart. Each frame is also started in a different way. The plain and long-blanking frames separate the clamped row length from the raw one. The skip frames separate pair-wise skipping from plain decimation through the address sequence 0,1,4,5. The line strobe formats differ only during blanking rows and at the frame edges, so they are compared cycle by cycle. Geometry writes land mid-frame, with and without hold, so only correct shadowing produces the expected frame shapes. Snapshot idle gaps and restarts check that the start of each frame lands on the right clock.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    localparam int ADDR_W  = 11;
    localparam int HB_W    = 11;
    localparam int VB_W    = 11;
    localparam int INT_W   = 14;
    localparam int PIX_W   = 10;
    localparam int ROW_OVH = 244;
    localparam int HB_MIN  = 19;

    localparam int CNT_W = ADDR_W + 1;
    localparam int H_W   = ADDR_W + 3;
    localparam int V_W   = INT_W + 1;

    typedef enum logic [1:0] {
        LV_NORMAL  = 2'b00,
        LV_CONT    = 2'b01,
        LV_XOR     = 2'b10,
        LV_XOR_ALT = 2'b11
    } lv_fmt_e;

    typedef struct packed {
        logic [ADDR_W-1:0] row_first;
        logic [ADDR_W-1:0] col_first;
        logic [ADDR_W-1:0] rows_m1;
        logic [ADDR_W-1:0] cols_m1;
        logic [HB_W-1:0]   hblank;
        logic [VB_W-1:0]   vblank;
        logic [INT_W-1:0]  int_rows;
        logic              row_skip;
        logic              col_skip;
    } rdt_geom_t;

    typedef struct packed {
        lv_fmt_e           lv_fmt;
        logic              snap_en;
        logic              hold;
        logic              tpat_en;
        logic [PIX_W-1:0]  tpat_val;
    } rdt_mode_t;

    typedef struct packed {
        rdt_geom_t geom;
        rdt_mode_t mode;
    } rdt_cfg_t;

    localparam int CFG_W = $bits(rdt_cfg_t);

    // number of indices kept out of last_m1+1 when pair skipping may be on
    function automatic logic [CNT_W-1:0] kept_count(input logic [ADDR_W-1:0] last_m1,
                                                    input logic skip);
        logic [CNT_W-1:0] n;
        n = CNT_W'(last_m1) + CNT_W'(1);
        if (!skip) return n;
        return ((n >> 2) << 1) + ((n[1:0] >= 2'd2) ? CNT_W'(2) : CNT_W'(n[1:0]));
    endfunction

    // map an output index to an offset from the window start
    function automatic logic [ADDR_W-1:0] kept_offset(input logic [ADDR_W-1:0] idx,
                                                      input logic skip);
        if (!skip) return idx;
        return ((idx >> 1) << 2) | {{(ADDR_W-1){1'b0}}, idx[0]};
    endfunction

    function automatic logic [H_W-1:0] row_length(input logic [CNT_W-1:0] npix,
                                                  input logic [HB_W-1:0] hb);
        logic [HB_W-1:0] hb_eff;
        hb_eff = (hb < HB_W'(HB_MIN)) ? HB_W'(HB_MIN) : hb;
        return H_W'(npix) + H_W'(ROW_OVH) + H_W'(hb_eff) - H_W'(HB_MIN);
    endfunction

    function automatic logic [V_W-1:0] frame_rows(input logic [CNT_W-1:0] nrows,
                                                  input logic [VB_W-1:0] vb,
                                                  input logic [INT_W-1:0] irows);
        logic [V_W-1:0] base;
        base = V_W'(nrows) + V_W'(vb) + V_W'(1);
        return (V_W'(irows) > base) ? V_W'(irows) : base;
    endfunction

endpackage

// File: rtl/rdt_shadow.sv
module rdt_shadow
    import rdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rdt_geom_t geom_in,
    output rdt_geom_t geom_q
);

    always_ff @(posedge clk) begin
        if (rst)       geom_q <= '0;
        else if (load) geom_q <= geom_in;
    end

    // R8: geometry only moves when a frame start allows it
    a_r8_geom_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(geom_q));

endmodule

// File: rtl/rdt_axis.sv
module rdt_axis
    import rdt_pkg::*;
(
    input  logic [ADDR_W-1:0] first,
    input  logic [ADDR_W-1:0] last_m1,
    input  logic [ADDR_W-1:0] idx,
    input  logic              skip,
    output logic [CNT_W-1:0]  kept,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        kept = kept_count(last_m1, skip);
        addr = first + kept_offset(idx, skip);
    end

endmodule

// File: rtl/rdt_hcount.sv
module rdt_hcount #(
    parameter int CW = 12,
    parameter int HW = 14,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] npix,
    input  logic [HW-1:0] row_len,
    output logic [HW-1:0] hcnt,
    output logic          line_end,
    output logic          pix_phase,
    output logic [AW-1:0] col_idx
);

    assign line_end  = run && (hcnt == row_len - HW'(1));
    assign pix_phase = run && (hcnt != '0) && (hcnt <= HW'(npix));
    assign col_idx   = AW'(hcnt - HW'(1));

    always_ff @(posedge clk) begin
        if (rst)      hcnt <= '0;
        else if (clr) hcnt <= '0;
        else if (run) hcnt <= line_end ? '0 : hcnt + HW'(1);
    end

    // R2: the position never leaves the programmed row length
    a_r2_hcnt_in_row: assert property (@(posedge clk) disable iff (rst)
        run |-> (hcnt < row_len));

endmodule

// File: rtl/rdt_vseq.sv
module rdt_vseq #(
    parameter int VW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          snap,
    input  logic          trig,
    input  logic          restart,
    input  logic          line_end,
    input  logic [VW-1:0] total,
    output logic          running,
    output logic [VW-1:0] vrow,
    output logic          start,
    output logic          frame_end
);

    logic stop;

    assign frame_end = line_end && (vrow == total - VW'(1));
    assign start     = running ? (restart || (frame_end && !snap))
                               : (!snap || trig || restart);
    assign stop      = running && frame_end && snap && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            vrow    <= '0;
        end else if (start) begin
            running <= 1'b1;
            vrow    <= '0;
        end else if (stop) begin
            running <= 1'b0;
        end else if (line_end) begin
            vrow <= vrow + VW'(1);
        end
    end

    // R9: a snapshot frame is followed by idle
    a_r9_single_shot: assert property (@(posedge clk) disable iff (rst)
        (running && line_end && (vrow == total - VW'(1)) && snap && !restart) |=> !running);

    // R9: without a start request snapshot mode stays idle
    a_r9_wait_trigger: assert property (@(posedge clk) disable iff (rst)
        (!running && snap && !trig && !restart) |=> !running);

endmodule

// File: rtl/rdt_readout_timer.sv
module rdt_readout_timer
    import rdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_bus,
    input  logic              trigger,
    input  logic              restart,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [PIX_W-1:0]  pix_out
);

    rdt_cfg_t          cfg_live;
    rdt_geom_t         geom_q;
    logic              start, frame_end, running, line_end, pix_phase;
    logic [H_W-1:0]    hcnt, rlen;
    logic [V_W-1:0]    vrow, total;
    logic [CNT_W-1:0]  n_cols, n_rows;
    logic [ADDR_W-1:0] col_idx, row_idx;
    logic              in_act_row, last_act, act_pix, fv;

    assign cfg_live = rdt_cfg_t'(cfg_bus);

    rdt_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (start && !cfg_live.mode.hold),
        .geom_in (cfg_live.geom),
        .geom_q  (geom_q)
    );

    assign row_idx = ADDR_W'(vrow);

    rdt_axis u_row_axis (
        .first   (geom_q.row_first),
        .last_m1 (geom_q.rows_m1),
        .idx     (row_idx),
        .skip    (geom_q.row_skip),
        .kept    (n_rows),
        .addr    (row_addr)
    );

    rdt_axis u_col_axis (
        .first   (geom_q.col_first),
        .last_m1 (geom_q.cols_m1),
        .idx     (col_idx),
        .skip    (geom_q.col_skip),
        .kept    (n_cols),
        .addr    (col_addr)
    );

    assign rlen  = row_length(n_cols, geom_q.hblank);
    assign total = frame_rows(n_rows, geom_q.vblank, geom_q.int_rows);

    rdt_hcount #(.CW(CNT_W), .HW(H_W), .AW(ADDR_W)) u_hcount (
        .clk       (clk),
        .rst       (rst),
        .clr       (start),
        .run       (running),
        .npix      (n_cols),
        .row_len   (rlen),
        .hcnt      (hcnt),
        .line_end  (line_end),
        .pix_phase (pix_phase),
        .col_idx   (col_idx)
    );

    rdt_vseq #(.VW(V_W)) u_vseq (
        .clk       (clk),
        .rst       (rst),
        .snap      (cfg_live.mode.snap_en),
        .trig      (trigger),
        .restart   (restart),
        .line_end  (line_end),
        .total     (total),
        .running   (running),
        .vrow      (vrow),
        .start     (start),
        .frame_end (frame_end)
    );

    // frame and line strobes
    always_comb begin
        in_act_row = running && (vrow < V_W'(n_rows));
        last_act   = (vrow == V_W'(n_rows) - V_W'(1));
        fv         = in_act_row && !(last_act && (hcnt > H_W'(n_cols)));
        act_pix    = in_act_row && pix_phase;
        case (cfg_live.mode.lv_fmt)
            LV_NORMAL: line_valid = act_pix;
            LV_CONT:   line_valid = pix_phase;
            default:   line_valid = pix_phase ^ fv;
        endcase
    end

    assign frame_valid = fv;

    // pixel data or alternating test word
    always_comb begin
        if (!act_pix)                   pix_out = '0;
        else if (!cfg_live.mode.tpat_en) pix_out = pix_in;
        else if (col_addr[0])           pix_out = ~cfg_live.mode.tpat_val;
        else                            pix_out = cfg_live.mode.tpat_val;
    end

    // R12: nothing is framed while idle
    a_r12_idle_dark: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!frame_valid && !line_valid));

    // R5: normal format never strobes a line outside the frame
    a_r5_line_in_frame: assert property (@(posedge clk) disable iff (rst)
        (cfg_live.mode.lv_fmt == LV_NORMAL && line_valid) |-> frame_valid);

    // R6: the first line strobe follows the frame strobe by one clock
    a_r6_frame_leads: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame_valid) && cfg_live.mode.lv_fmt == LV_NORMAL) |=> line_valid);

    // R10: restart rewinds to the first row and column phase
    a_r10_restart_rewinds: assert property (@(posedge clk) disable iff (rst)
        (running && restart) |=> (vrow == '0 && hcnt == '0 && running));

    // R4: skipped column addresses never carry offset bit 1
    a_r4_col_pairs: assert property (@(posedge clk) disable iff (rst)
        (act_pix && geom_q.col_skip) |-> !(ADDR_W'(col_addr - geom_q.col_first) & ADDR_W'(2)));

endmodule

// File: tb/rdt_readout_timer_tb_top.sv
module rdt_readout_timer_tb_top;
    import rdt_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst;
    rdt_cfg_t          cfg;
    logic              trigger, restart;
    logic [PIX_W-1:0]  pix_in, pix_out;
    logic              fv, lv;
    logic [ADDR_W-1:0] ra, ca;

    // pixel source model: word depends on the address it is asked for
    assign pix_in = PIX_W'(ra ^ ca);

    rdt_readout_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_bus     (cfg),
        .trigger     (trigger),
        .restart     (restart),
        .pix_in      (pix_in),
        .frame_valid (fv),
        .line_valid  (lv),
        .row_addr    (ra),
        .col_addr    (ca),
        .pix_out     (pix_out)
    );

    typedef struct {
        bit    fv;
        bit    lv;
        bit    px;
        int    row;
        int    col;
        int    pix;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // monitor: one expected item per clock, sampled at the falling edge
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (fv !== e.fv || lv !== e.lv ||
                (e.px && (int'(ra) != e.row || int'(ca) != e.col || int'(pix_out) != e.pix))) begin
                errors++;
                $display("FAIL %s t=%0t fv,lv=%b%b exp %b%b row=%0d exp %0d col=%0d exp %0d pix=%0h exp %0h",
                         e.tag, $time, fv, lv, e.fv, e.lv, ra, e.row, ca, e.col, pix_out, e.pix);
            end
        end
    end

    task automatic push_idle(input int n, input string tag);
        exp_t e;
        for (int i = 0; i < n; i++) begin
            e = '{fv: 0, lv: 0, px: 0, row: 0, col: 0, pix: 0, tag: tag};
            q.push_back(e);
        end
    endtask

    // expected frame built from the requirement formulas
    task automatic push_frame(input rdt_geom_t g, input rdt_mode_t m, input int limit,
                              input string tag);
        int   roff[$];
        int   coff[$];
        int   hb, rt, total, nr, nc, pushed;
        bit   act, pcol, efv, elv;
        exp_t e;
        for (int k = 0; k <= int'(g.rows_m1); k++)
            if (!g.row_skip || ((k >> 1) & 1) == 0) roff.push_back(k);
        for (int k = 0; k <= int'(g.cols_m1); k++)
            if (!g.col_skip || ((k >> 1) & 1) == 0) coff.push_back(k);
        nr = roff.size();
        nc = coff.size();
        hb = (int'(g.hblank) < 19) ? 19 : int'(g.hblank);
        rt = nc + 244 + hb - 19;
        total = nr + int'(g.vblank) + 1;
        if (int'(g.int_rows) > total) total = int'(g.int_rows);
        pushed = 0;
        for (int r = 0; r < total; r++) begin
            for (int h = 0; h < rt; h++) begin
                if (limit >= 0 && pushed >= limit) return;
                act  = (r < nr);
                pcol = (h >= 1 && h <= nc);
                efv  = act && !(r == nr - 1 && h > nc);
                case (m.lv_fmt)
                    LV_NORMAL: elv = act && pcol;
                    LV_CONT:   elv = pcol;
                    default:   elv = pcol ^ efv;
                endcase
                e = '{fv: efv, lv: elv, px: act && pcol, row: 0, col: 0, pix: 0, tag: tag};
                if (act && pcol) begin
                    e.row = int'(g.row_first) + roff[r];
                    e.col = int'(g.col_first) + coff[h-1];
                    if (m.tpat_en) e.pix = (e.col & 1) ? (~int'(m.tpat_val) & 'h3FF) : int'(m.tpat_val);
                    else           e.pix = (e.row ^ e.col) & 'h3FF;
                end
                q.push_back(e);
                pushed++;
            end
        end
    endtask

    task automatic wait_tail();
        do begin
            @(negedge clk);
            #1;
        end while (q.size() >= 100);
    endtask

    task automatic wait_empty();
        while (q.size() != 0) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        rdt_geom_t ga, gb, gc, gf, gg;
        rdt_mode_t ma, mt;

        ga = '{row_first: 11'd2, col_first: 11'd4, rows_m1: 11'd3, cols_m1: 11'd7,
               hblank: 11'd5, vblank: 11'd1, int_rows: 14'd0, row_skip: 1'b0, col_skip: 1'b0};
        ma = '{lv_fmt: LV_NORMAL, snap_en: 1'b0, hold: 1'b0, tpat_en: 1'b0, tpat_val: 10'h2A5};

        rst = 1'b1; trigger = 1'b0; restart = 1'b0;
        cfg = '{geom: ga, mode: ma};

        // R12: strobes low while reset is held
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (fv !== 1'b0 || lv !== 1'b0) begin
                errors++;
                $display("FAIL R12 reset strobes fv,lv=%b%b exp 00", fv, lv);
            end
        end

        // R1 R3 R6 R12: first free-running frame right after release, clamped hblank (R2)
        #1 rst = 1'b0;
        push_frame(ga, ma, -1, "R1 R3 R6 R12");

        // R2 R8: wider blanking written mid-frame, used from the next frame on
        gb = ga; gb.hblank = 11'd40;
        wait_tail(); cfg.geom = gb; push_frame(gb, ma, -1, "R2 R8");

        // R4: pair skipping on both axes
        gc = ga; gc.rows_m1 = 11'd5; gc.row_skip = 1'b1; gc.col_skip = 1'b1;
        wait_tail(); cfg.geom = gc; push_frame(gc, ma, -1, "R4");

        // R5: continuous line strobe, then the XOR format
        wait_tail(); cfg.mode.lv_fmt = LV_CONT;
        push_frame(gc, cfg.mode, -1, "R5 continuous");
        wait_tail(); cfg.mode.lv_fmt = LV_XOR;
        push_frame(gc, cfg.mode, -1, "R5 xor");

        // R7: integration rows lengthen the frame
        gf = ga; gf.int_rows = 14'd12;
        wait_tail(); cfg.mode.lv_fmt = LV_NORMAL; cfg.geom = gf;
        push_frame(gf, cfg.mode, -1, "R7");

        // R8: new width with hold set keeps the old geometry, release applies it
        gg = gf; gg.cols_m1 = 11'd5;
        wait_tail(); cfg.geom = gg; cfg.mode.hold = 1'b1;
        push_frame(gf, cfg.mode, -1, "R8 hold");
        wait_tail(); cfg.mode.hold = 1'b0;
        push_frame(gg, cfg.mode, -1, "R8 release");

        // R11: test pattern with unchanged timing
        gg.int_rows = 14'd0;
        wait_tail(); cfg.geom = gg; cfg.mode.tpat_en = 1'b1;
        mt = cfg.mode;
        push_frame(gg, mt, -1, "R11");

        // R10: abandon part way through the next frame
        wait_tail();
        push_frame(gg, mt, 300, "R10 partial");
        wait_empty();
        restart = 1'b1;
        push_frame(gg, mt, -1, "R10");
        @(posedge clk); #1 restart = 1'b0;

        // R9: snapshot idles, then one frame per trigger
        wait_tail(); cfg.mode.snap_en = 1'b1;
        push_idle(30, "R9 idle");
        wait_empty();
        trigger = 1'b1;
        push_frame(gg, cfg.mode, -1, "R9 trigger");
        push_idle(30, "R9 idle after shot");
        @(posedge clk); #1 trigger = 1'b0;
        wait_empty();
        restart = 1'b1;
        push_frame(gg, cfg.mode, -1, "R9 R10 restart start");
        @(posedge clk); #1 restart = 1'b0;

        // R9: leaving snapshot mode resumes back-to-back frames
        wait_tail(); cfg.mode.snap_en = 1'b0;
        push_frame(gg, cfg.mode, -1, "R9 resume");
        wait_empty();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule